// File: doc/BRIEF.md
# Interrupt Claim/Complete Target Controller

This block serves one interrupt context (one hart privilege level) of a platform interrupt controller. Gateways hand it single-cycle raise pulses, one per source. It holds the resulting pending bits itself. It compares each pending source's priority, picks the winner, and drives a registered request line to the hart whenever the winner's priority is strictly above the context threshold.

Software takes the interrupt through a claim read, which returns the winning source ID, clears that source's pending bit and records the ID as outstanding. While a claim is outstanding the context raises no new request. A repeated claim before completion returns the outstanding ID again rather than zero, so a core that re-reads the claim port never loses the interrupt it is handling. A completion write carrying the outstanding ID ends the claim, and the request line is then evaluated afresh. Each context is one instance of this block.

Top module: `irq_target_ctx`

## Requirements
- R1: After reset `irq_o` is 0, `claim_rdata_o` is 0, no source is pending and no claim is outstanding.
- R2: ID 0 means "no interrupt": a claim read with no pending source of nonzero priority returns 0 and changes no state.
- R3: A claim read with no outstanding claim returns the pending source of highest priority, with ties going to the lowest ID. It clears that source's pending bit and records its ID as outstanding. The threshold does not affect the claim. `claim_rdata_o` carries the value in the cycle after the strobe and is 0 in every other cycle.
- R4: `irq_o` is a register. In each cycle it equals (best pending priority > `threshold_i`) AND (best ID != 0) AND (no claim outstanding), evaluated on the state and inputs of the previous cycle.
- R5: While a claim is outstanding, `irq_o` stays 0 from the cycle after the claim is recorded, even if sources of any priority become pending.
- R6: A claim read while a claim is outstanding returns the outstanding ID again. It claims no new source and clears no pending bit.
- R7: A completion write whose full `DATA_W`-bit data equals the outstanding ID ends the claim. `irq_o` reflects any waiting source one cycle later.
- R8: A completion write whose data differs from the outstanding ID, or that arrives with no claim outstanding, is ignored and leaves the outstanding claim in place.
- R9: Within one cycle, a completion is applied before a claim, so a claim read strobed together with a matching completion takes a fresh source. A raise of a source arriving in the same cycle as its claim leaves that source pending.
- R10: A source with priority 0 never drives `irq_o` and is never returned by a claim.
- R11: Source s (1 to `NUM_SRC`) uses raise bit s-1 and the priority field `src_prio_i[(s-1)*PRIO_W +: PRIO_W]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| src_raise_i | input | NUM_SRC | One-cycle pulses that set pending bits, bit s-1 for source s |
| src_prio_i | input | NUM_SRC*PRIO_W | Packed per-source priorities |
| threshold_i | input | PRIO_W | Context threshold |
| claim_rd_i | input | 1 | Claim read strobe |
| claim_rdata_o | output | DATA_W | Claimed ID, valid the cycle after the strobe |
| cmpl_wr_i | input | 1 | Completion write strobe |
| cmpl_wdata_i | input | DATA_W | Completion data (ID being completed) |
| irq_o | output | 1 | Registered interrupt request to the hart |

## Verification
Two pairs of functions can land in one cycle: a completion and a claim, and a raise pulse and the claim that clears the same source. The bench provokes each pair directly. It strobes a claim together with the matching completion while another source waits, and it strobes a raise of the winning source together with its claim. It judges the returned ID and the later claims against the ordering of R9. A behavioural reference model then follows long random mixes of raises, priority and threshold changes, claims, and matching and foreign completions, and it compares `irq_o` and `claim_rdata_o` on every clock.

// File: rtl/irqtgt_pkg.sv
package irqtgt_pkg;
    // Upper bound on sources per context; IDs 1..MAX_SRC, ID 0 reserved.
    localparam int unsigned MAX_SRC   = 31;
    localparam int unsigned MAX_ID_W  = 5;

    function automatic int unsigned id_bits(input int unsigned nsrc);
        return $clog2(nsrc + 1);
    endfunction
endpackage

// File: rtl/irqtgt_pend_bank.sv
module irqtgt_pend_bank #(
    parameter int unsigned N = 31
) (
    input  logic         clk_i,
    input  logic         rst_ni,
    input  logic [N-1:0] raise_i,
    input  logic [N-1:0] clr_i,
    output logic [N-1:0] pend_o
);
    typedef struct packed {
        logic [N-1:0] pend;
    } bank_st_t;

    bank_st_t st_d, st_q;

    // Clear from a claim first, then raise: a same-cycle raise survives.
    always_comb begin
        st_d      = st_q;
        st_d.pend = (st_q.pend & ~clr_i) | raise_i;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    assign pend_o = st_q.pend;

    // R3: a claim clears at most one source per cycle
    a_r3_single_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $onehot0(clr_i));

    // R9: every raised bit is pending in the next cycle, claim or not
    a_r9_raise_sticks: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (raise_i != '0) |=> ((pend_o & $past(raise_i)) == $past(raise_i)));
endmodule

// File: rtl/irqtgt_arbiter.sv
module irqtgt_arbiter #(
    parameter int unsigned N  = 31,
    parameter int unsigned PW = 3,
    parameter int unsigned IW = 5
) (
    input  logic [N-1:0]    pend_i,
    input  logic [N*PW-1:0] prio_i,
    output logic [IW-1:0]   best_id_o,
    output logic [PW-1:0]   best_pri_o
);
    logic [PW-1:0] pri_a [N];

    for (genvar g = 0; g < N; g++) begin : g_unpack
        assign pri_a[g] = prio_i[g*PW +: PW];
    end

    // Strict compare: equal priority keeps the lower ID; priority 0 never wins.
    always_comb begin
        best_id_o  = '0;
        best_pri_o = '0;
        for (int s = 0; s < N; s++) begin
            if (pend_i[s] && (pri_a[s] > best_pri_o)) begin
                best_pri_o = pri_a[s];
                best_id_o  = IW'(s + 1);
            end
        end
    end
endmodule

// File: rtl/irqtgt_claim_ctrl.sv
module irqtgt_claim_ctrl #(
    parameter int unsigned N  = 31,
    parameter int unsigned PW = 3,
    parameter int unsigned IW = 5,
    parameter int unsigned DW = 32
) (
    input  logic          clk_i,
    input  logic          rst_ni,
    input  logic [IW-1:0] best_id_i,
    input  logic [PW-1:0] best_pri_i,
    input  logic [PW-1:0] thr_i,
    input  logic          rd_i,
    input  logic          wr_i,
    input  logic [DW-1:0] wdata_i,
    output logic [N-1:0]  clr_o,
    output logic [DW-1:0] rdata_o,
    output logic          irq_o
);
    typedef struct packed {
        logic [IW-1:0] held;
        logic [DW-1:0] rdata;
        logic          irq;
    } ctrl_st_t;

    ctrl_st_t st_d, st_q;
    logic     done;
    logic     take;

    always_comb begin
        st_d       = st_q;
        st_d.rdata = '0;
        take       = 1'b0;
        done       = wr_i && (st_q.held != '0) && (wdata_i == DW'(st_q.held));
        if (done) st_d.held = '0;
        if (rd_i) begin
            if (st_d.held != '0) begin
                st_d.rdata = DW'(st_d.held);
            end else if (best_id_i != '0) begin
                take       = 1'b1;
                st_d.held  = best_id_i;
                st_d.rdata = DW'(best_id_i);
            end
        end
        st_d.irq = (best_pri_i > thr_i) && (best_id_i != '0) && (st_q.held == '0);
        for (int s = 0; s < N; s++) begin
            clr_o[s] = take && (best_id_i == IW'(s + 1));
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    assign rdata_o = st_q.rdata;
    assign irq_o   = st_q.irq;

    // R5: no request in the cycle after a claim is held
    a_r5_quiet_while_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (st_q.held != '0) |=> !irq_o);

    // R6: a repeated claim echoes the held ID
    a_r6_repeat_echo: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (rd_i && !wr_i && (st_q.held != '0)) |=> (rdata_o == DW'($past(st_q.held))));

    // R3: read data is zero outside the cycle after a claim strobe
    a_r3_idle_rdata_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !rd_i |=> (rdata_o == '0));

    // R8: a foreign completion keeps the held claim
    a_r8_foreign_kept: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (wr_i && !rd_i && (wdata_i != DW'(st_q.held))) |=> $stable(st_q.held));

    // R7: a matching completion frees the context
    a_r7_complete_frees: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (wr_i && !rd_i && (st_q.held != '0) && (wdata_i == DW'(st_q.held)))
        |=> (st_q.held == '0));
endmodule

// File: rtl/irq_target_ctx.sv
module irq_target_ctx #(
    parameter int unsigned NUM_SRC = 31,
    parameter int unsigned PRIO_W  = 3,
    parameter int unsigned DATA_W  = 32
) (
    input  logic                      clk_i,
    input  logic                      rst_ni,
    input  logic [NUM_SRC-1:0]        src_raise_i,
    input  logic [NUM_SRC*PRIO_W-1:0] src_prio_i,
    input  logic [PRIO_W-1:0]         threshold_i,
    input  logic                      claim_rd_i,
    output logic [DATA_W-1:0]         claim_rdata_o,
    input  logic                      cmpl_wr_i,
    input  logic [DATA_W-1:0]         cmpl_wdata_i,
    output logic                      irq_o
);
    localparam int unsigned ID_W = irqtgt_pkg::id_bits(NUM_SRC);

    logic [NUM_SRC-1:0] pend;
    logic [NUM_SRC-1:0] clr;
    logic [ID_W-1:0]    best_id;
    logic [PRIO_W-1:0]  best_pri;

    irqtgt_pend_bank #(.N(NUM_SRC)) u_bank (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .raise_i (src_raise_i),
        .clr_i   (clr),
        .pend_o  (pend)
    );

    irqtgt_arbiter #(.N(NUM_SRC), .PW(PRIO_W), .IW(ID_W)) u_arb (
        .pend_i     (pend),
        .prio_i     (src_prio_i),
        .best_id_o  (best_id),
        .best_pri_o (best_pri)
    );

    irqtgt_claim_ctrl #(.N(NUM_SRC), .PW(PRIO_W), .IW(ID_W), .DW(DATA_W)) u_ctrl (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .best_id_i  (best_id),
        .best_pri_i (best_pri),
        .thr_i      (threshold_i),
        .rd_i       (claim_rd_i),
        .wr_i       (cmpl_wr_i),
        .wdata_i    (cmpl_wdata_i),
        .clr_o      (clr),
        .rdata_o    (claim_rdata_o),
        .irq_o      (irq_o)
    );

    // R10: the winner always has a nonzero priority
    a_r10_zero_prio_loses: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (best_id != '0) |-> (best_pri != '0));

    // R3: the winner is a pending source
    a_r3_winner_pending: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (best_id != '0) |-> pend[best_id - 1'b1]);
endmodule

// File: tb/tb_irq_target_ctx.sv
`timescale 1ns/1ps
module tb_irq_target_ctx;
    localparam int N  = 31;
    localparam int PW = 3;
    localparam int DW = 32;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [N-1:0]    raise = '0;
    logic [N*PW-1:0] prio = '0;
    logic [PW-1:0]   thr = '0;
    logic            rd = 1'b0;
    logic            wr = 1'b0;
    logic [DW-1:0]   wdata = '0;
    logic [DW-1:0]   rdata;
    logic            irq;

    int n_chk = 0;
    int n_fail = 0;
    bit cmp_on = 1'b0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    irq_target_ctx dut (
        .clk_i(clk), .rst_ni(rst_n), .src_raise_i(raise), .src_prio_i(prio),
        .threshold_i(thr), .claim_rd_i(rd), .claim_rdata_o(rdata),
        .cmpl_wr_i(wr), .cmpl_wdata_i(wdata), .irq_o(irq)
    );

    // ---------------- behavioural reference model ----------------
    bit [N:1] m_pend;
    int       m_held, m_rdata, m_irq;

    function automatic int prio_of(int s);
        return int'((prio >> ((s - 1) * PW)) & 3'b111);
    endfunction

    always @(posedge clk) begin
        int bid, bp, held2, rd2;
        if (!rst_n) begin
            m_pend = '0; m_held = 0; m_rdata = 0; m_irq = 0;
        end else begin
            bid = 0; bp = 0;
            for (int s = N; s >= 1; s--)
                if (m_pend[s] && prio_of(s) > 0 && prio_of(s) >= bp) begin
                    bp = prio_of(s); bid = s;
                end
            held2 = m_held;
            if (wr && m_held != 0 && wdata == DW'(m_held)) held2 = 0;
            rd2 = 0;
            if (rd) begin
                if (held2 != 0) rd2 = held2;
                else if (bid != 0) begin
                    rd2 = bid; held2 = bid; m_pend[bid] = 1'b0;
                end
            end
            m_irq   = (bp > int'(thr) && bid != 0 && m_held == 0) ? 1 : 0;
            m_held  = held2;
            m_rdata = rd2;
            for (int s = 1; s <= N; s++) if (raise[s-1]) m_pend[s] = 1'b1;
        end
    end

    always @(negedge clk) begin
        if (cmp_on && !done) begin
            n_chk++;
            if (int'(irq) != m_irq) begin
                n_fail++;
                $display("FAIL R4 model irq: actual %0d expected %0d at %0t", irq, m_irq, $time);
            end
            n_chk++;
            if (rdata != DW'(m_rdata)) begin
                n_fail++;
                $display("FAIL R3 model rdata: actual %0d expected %0d at %0t", rdata, m_rdata, $time);
            end
        end
    end

    // ---------------- helpers ----------------
    task automatic chk(string tag, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic set_prio(int s, int p);
        prio[(s-1)*PW +: PW] = PW'(p);
    endtask

    task automatic pulse_raise(int s);
        raise[s-1] = 1'b1;
        @(negedge clk);
        raise = '0;
    endtask

    // strobe a claim, return the ID shown in the following cycle
    task automatic claim(output int id);
        rd = 1'b1;
        @(negedge clk);
        rd = 1'b0;
        id = int'(rdata);
    endtask

    task automatic complete(logic [DW-1:0] d);
        wr = 1'b1; wdata = d;
        @(negedge clk);
        wr = 1'b0; wdata = '0;
    endtask

    task automatic finish_up();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        #(200000 * 10);
        n_fail++;
        $display("FAIL watchdog: actual hung expected finish");
        finish_up();
    end

    initial begin
        int id;
        repeat (3) @(negedge clk);
        chk("R1 reset irq", int'(irq), 0);
        chk("R1 reset rdata", int'(rdata), 0);
        rst_n = 1'b1;
        @(negedge clk);
        cmp_on = 1'b1;

        // R2: nothing pending
        claim(id); chk("R2 empty claim", id, 0);

        // R10: priority-0 source neither interrupts nor is claimed
        set_prio(4, 0); pulse_raise(4);
        @(negedge clk); chk("R10 zero prio irq", int'(irq), 0);
        claim(id); chk("R10 zero prio claim", id, 0);

        // R4 / R11: source 5 prio 3 over threshold 1
        thr = 3'd1; set_prio(5, 3); pulse_raise(5);
        chk("R4 irq one cycle after pending", int'(irq), 0);
        @(negedge clk); chk("R4 irq raised", int'(irq), 1);

        // R3 claim, R5 quiet
        claim(id); chk("R3 claim id", id, 5);
        @(negedge clk); chk("R5 irq dropped", int'(irq), 0);
        set_prio(7, 7); pulse_raise(7);
        repeat (2) @(negedge clk); chk("R5 held blocks higher", int'(irq), 0);

        // R6 repeat claim
        claim(id); chk("R6 repeat claim", id, 5);

        // R8 foreign completions
        complete(32'd6);
        complete(32'd5 | (32'd1 << 20));
        claim(id); chk("R8 foreign ignored", id, 5);

        // R7 matching completion
        complete(32'd5);
        chk("R7 irq one cycle later", int'(irq), 0);
        @(negedge clk); chk("R7 irq after complete", int'(irq), 1);
        claim(id); chk("R3 higher prio wins", id, 7);

        // R3 tie to lowest ID
        set_prio(3, 2); set_prio(9, 2);
        raise[2] = 1'b1; raise[8] = 1'b1; @(negedge clk); raise = '0;
        complete(32'd7);
        claim(id); chk("R3 tie lowest id", id, 3);
        complete(32'd3);

        // R4 strict threshold; claim ignores threshold
        thr = 3'd2;
        repeat (2) @(negedge clk); chk("R4 equal threshold no irq", int'(irq), 0);
        claim(id); chk("R3 claim ignores threshold", id, 9);
        thr = 3'd0;

        // R9 completion and claim same cycle: source 12 waiting
        set_prio(12, 1); pulse_raise(12);
        rd = 1'b1; wr = 1'b1; wdata = 32'd9;
        @(negedge clk);
        rd = 1'b0; wr = 1'b0; wdata = '0;
        chk("R9 complete then claim", int'(rdata), 12);
        complete(32'd12);

        // R9 raise and claim same cycle on one source
        set_prio(20, 4); pulse_raise(20);
        raise[19] = 1'b1; rd = 1'b1;
        @(negedge clk);
        raise = '0; rd = 1'b0;
        chk("R9 claim with raise", int'(rdata), 20);
        complete(32'd20);
        claim(id); chk("R9 raise survived claim", id, 20);
        complete(32'd20);
        claim(id); chk("R2 drained", id, 0);

        // random mix against the model
        for (int c = 0; c < 4000; c++) begin
            raise = '0;
            if ($urandom_range(3) == 0) raise[$urandom_range(N-1)] = 1'b1;
            if ($urandom_range(15) == 0) set_prio($urandom_range(N, 1), $urandom_range(7));
            if ($urandom_range(31) == 0) thr = PW'($urandom_range(7));
            rd = ($urandom_range(3) == 0);
            wr = ($urandom_range(3) == 0);
            wdata = ($urandom_range(1) == 0) ? DW'(m_held) : DW'($urandom_range(N));
            @(negedge clk);
        end
        raise = '0; rd = 1'b0; wr = 1'b0;
        @(negedge clk);
        finish_up();
    end
endmodule